// File: doc/BRIEF.md
# Converter Select and Result Register Block

This block sits between a processor's register port and the sequencer of an analog-to-digital converter. It holds an 8-bit select register with a 2-bit reference field, a left-adjust flag and a 5-bit channel/gain field. It also presents the 10-bit conversion result through two 8-bit read registers, one for the low byte and one for the high byte.

Reference and channel writes are staged. While a conversion is running, the value driven to the converter does not move. The staged value takes over on the edge where the conversion-done strobe arrives. The alignment flag acts at once: the stored raw result is reformatted on the read path, even in the middle of a conversion.

Register addresses on `reg_addr`: 0 is the select register, 1 is the result low byte, 2 is the result high byte, and 3 reads as zero.

Top module: `adc_sel_regs`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the select register reads 0x00, both result registers read 0x00, `conv_busy` is 0, and `act_ref` and `act_chan` are 0.
- R2: A read of address 0 returns the last byte written there, all 8 bits. The layout is bits 7:6 reference, bit 5 left-adjust, bits 4:0 channel. Reference code 2'b10 is reserved and is stored and returned like any other code.
- R3: When no conversion is running, a write to address 0 updates `act_ref` (from bits 7:6) and `act_chan` (from bits 4:0) on the clock edge that samples the write. Before that edge they keep their old values.
- R4: While a conversion is running, `act_ref` and `act_chan` hold their values. On the edge that samples `conv_done`, they take the most recently written reference and channel fields.
- R5: A write to address 0 in the same cycle as `conv_done` is the one that becomes active on that edge.
- R6: A change of the left-adjust bit changes the bytes read at addresses 1 and 2 on the edge that samples the write, including while a conversion is running.
- R7: When right-adjusted (bit 5 = 0), address 1 returns result bits 7:0. Address 2 returns result bits 9:8 in bits 1:0, and its bits 7:2 are zero.
- R8: When left-adjusted (bit 5 = 1), address 2 returns result bits 9:2. Address 1 returns result bits 1:0 in bits 7:6, and its bits 5:0 are zero. Bits move unchanged, with no sign extension.
- R9: The 10-bit result is captured only on the edge that samples `conv_done`. Writes to addresses 1 and 2 have no effect, and neither does `conv_start`.
- R10: `conv_busy` rises on the edge after `conv_start` and falls on the edge after `conv_done`. If both strobes arrive in the same cycle, it stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| conv_start | input | 1 | Conversion start strobe from sequencer |
| conv_done | input | 1 | Conversion done strobe |
| conv_result | input | 10 | Raw result, valid with `conv_done` |
| act_ref | output | 2 | Active reference select to converter |
| act_chan | output | 5 | Active channel/gain select to converter |
| conv_busy | output | 1 | Conversion in progress |

## Verification
Several rules are checked by assertions on every cycle:
- the active fields hold steady during a conversion and match the written copy whenever the block is idle;
- the busy flag follows the two strobes;
- the stored result moves only on done;
- the unused bits of each alignment are zero.

Other behaviour can only be shown by the bench's scenarios: the exact byte values for all 1024 results in both alignments, the same-cycle write-and-done case, the instant reformatting during a conversion, and the ignored writes to the result addresses.

// File: rtl/adcsel_pkg.sv
// Package: shared register addresses and field constants for the
// converter select/result register block.
package adcsel_pkg;
    typedef enum logic [1:0] {
        ADDR_SEL = 2'd0,
        ADDR_LO  = 2'd1,
        ADDR_HI  = 2'd2,
        ADDR_RSV = 2'd3
    } reg_addr_e;

    // Reference select codes; 2'b10 is reserved and stored unfiltered.
    localparam logic [1:0] REF_EXT_PIN = 2'b00;
    localparam logic [1:0] REF_SUPPLY  = 2'b01;
    localparam logic [1:0] REF_RSVD    = 2'b10;
    localparam logic [1:0] REF_INT_256 = 2'b11;
endpackage

// File: rtl/adcsel_stage.sv
// Module: adcsel_stage
// Holds the written and active copies of the reference and channel fields,
// the left-adjust flag and the conversion busy state. Assumes the converter
// sequencer pulses conv_start and conv_done for one cycle each.
module adcsel_stage #(
    parameter int REF_W  = 2,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [REF_W-1:0]  wr_ref_in,
    input  logic              wr_left_in,
    input  logic [CHAN_W-1:0] wr_chan_in,
    input  logic              conv_start,
    input  logic              conv_done,
    output logic [REF_W-1:0]  wr_ref,
    output logic              wr_left,
    output logic [CHAN_W-1:0] wr_chan,
    output logic [REF_W-1:0]  act_ref,
    output logic [CHAN_W-1:0] act_chan,
    output logic              busy
);
    logic              load_act;
    logic [REF_W-1:0]  next_ref;
    logic [CHAN_W-1:0] next_chan;

    // Purpose: pick the staged value, letting a same-cycle write win.
    always_comb begin
        load_act  = !busy || conv_done;
        next_ref  = sel_wr ? wr_ref_in  : wr_ref;
        next_chan = sel_wr ? wr_chan_in : wr_chan;
    end

    // Purpose: register the written copy of the select fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ref  <= '0;
            wr_left <= 1'b0;
            wr_chan <= '0;
        end else if (sel_wr) begin
            wr_ref  <= wr_ref_in;
            wr_left <= wr_left_in;
            wr_chan <= wr_chan_in;
        end
    end

    // Purpose: update the active copy only when idle or at conversion end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_ref  <= '0;
            act_chan <= '0;
        end else if (load_act) begin
            act_ref  <= next_ref;
            act_chan <= next_chan;
        end
    end

    // Purpose: track whether a conversion is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= conv_start || (busy && !conv_done);
    end

    assert_hold_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> ($stable(act_ref) && $stable(act_chan)));
    assert_idle_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (act_ref == wr_ref && act_chan == wr_chan));
    assert_start_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy);
    assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && !conv_start) |=> !busy);
endmodule

// File: rtl/adcsel_result.sv
// Module: adcsel_result
// Captures the raw result on conv_done and formats it into low/high bytes
// on the read path. Assumes DATA_W < RES_W <= 2*DATA_W.
module adcsel_result #(
    parameter int RES_W  = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    input  logic              left,
    output logic [DATA_W-1:0] byte_lo,
    output logic [DATA_W-1:0] byte_hi
);
    localparam int LO_BITS = RES_W - DATA_W;
    localparam int PAD_W   = 2 * DATA_W - RES_W;

    logic [RES_W-1:0] res_q;

    // Purpose: hold the unformatted result of the last conversion.
    always_ff @(posedge clk) begin
        if (!rst_n)         res_q <= '0;
        else if (conv_done) res_q <= conv_result;
    end

    // Purpose: apply alignment combinationally so it acts at once.
    always_comb begin
        if (left) begin
            byte_hi = res_q[RES_W-1 -: DATA_W];
            byte_lo = {res_q[LO_BITS-1:0], {PAD_W{1'b0}}};
        end else begin
            byte_hi = {{PAD_W{1'b0}}, res_q[RES_W-1:DATA_W]};
            byte_lo = res_q[DATA_W-1:0];
        end
    end

    assert_capture_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done |=> $stable(res_q));
    assert_right_pad_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !left |-> (byte_hi[DATA_W-1:LO_BITS] == '0));
    assert_left_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        left |-> (byte_lo[PAD_W-1:0] == '0));
endmodule

// File: rtl/adc_sel_regs.sv
// Module: adc_sel_regs (top)
// Register block between a CPU port and a converter sequencer. Staged
// reference/channel select, immediate alignment, combinational read data.
module adc_sel_regs
    import adcsel_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RES_W  = 10,
    parameter int REF_W  = 2,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              conv_start,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic [REF_W-1:0]  act_ref,
    output logic [CHAN_W-1:0] act_chan,
    output logic              conv_busy
);
    localparam int LEFT_BIT = CHAN_W;
    localparam int REF_LSB  = CHAN_W + 1;

    logic              sel_wr;
    logic [REF_W-1:0]  wr_ref;
    logic              wr_left;
    logic [CHAN_W-1:0] wr_chan;
    logic [DATA_W-1:0] byte_lo;
    logic [DATA_W-1:0] byte_hi;

    assign sel_wr = reg_wr_en && (reg_addr == ADDR_SEL);

    adcsel_stage #(.REF_W(REF_W), .CHAN_W(CHAN_W)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_wr     (sel_wr),
        .wr_ref_in  (reg_wdata[REF_LSB +: REF_W]),
        .wr_left_in (reg_wdata[LEFT_BIT]),
        .wr_chan_in (reg_wdata[CHAN_W-1:0]),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .wr_ref     (wr_ref),
        .wr_left    (wr_left),
        .wr_chan    (wr_chan),
        .act_ref    (act_ref),
        .act_chan   (act_chan),
        .busy       (conv_busy)
    );

    adcsel_result #(.RES_W(RES_W), .DATA_W(DATA_W)) u_result (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .left        (wr_left),
        .byte_lo     (byte_lo),
        .byte_hi     (byte_hi)
    );

    // Purpose: read-data multiplexer over the register addresses.
    always_comb begin
        unique case (reg_addr)
            ADDR_SEL: reg_rdata = {wr_ref, wr_left, wr_chan};
            ADDR_LO:  reg_rdata = byte_lo;
            ADDR_HI:  reg_rdata = byte_hi;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: tb/adc_sel_regs_bench.sv
module adc_sel_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       conv_start = 1'b0;
    logic       conv_done = 1'b0;
    logic [9:0] conv_result = 10'd0;
    logic [1:0] act_ref;
    logic [4:0] act_chan;
    logic       conv_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_sel_regs u_adc_sel_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
        .conv_done(conv_done), .conv_result(conv_result), .act_ref(act_ref),
        .act_chan(act_chan), .conv_busy(conv_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_conv(input logic [9:0] r);
        conv_done = 1'b1; conv_result = r;
        tick();
        conv_done = 1'b0;
    endtask

    task automatic begin_conv();
        conv_start = 1'b1;
        tick();
        conv_start = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic [7:0] lo;
        logic [7:0] hi;
        repeat (3) tick();
        // R1: reset state
        rd(2'd0, d); chk("R1 sel reset", d, 0);
        rd(2'd1, d); chk("R1 lo reset", d, 0);
        rd(2'd2, d); chk("R1 hi reset", d, 0);
        chk("R1 busy reset", conv_busy, 0);
        chk("R1 act reset", {act_ref, act_chan}, 0);
        rst_n = 1'b1;
        tick();

        // R2: readback of every byte, including reserved reference code
        for (int v = 0; v < 256; v++) begin
            wr(2'd0, 8'(v));
            rd(2'd0, d); chk("R2 readback", d, v);
        end
        wr(2'd0, 8'h8A);
        rd(2'd0, d); chk("R2 reserved ref kept", d, 8'h8A);

        // R3: idle write takes effect on the sampling edge, not before
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hC7;
        #1;
        chk("R3 before edge", {act_ref, act_chan}, {2'b10, 5'h0A});
        tick();
        reg_wr_en = 1'b0;
        chk("R3 after edge", {act_ref, act_chan}, {2'b11, 5'h07});

        // R10, R4: staged write held during conversion
        begin_conv();
        chk("R10 busy after start", conv_busy, 1);
        wr(2'd0, 8'h53);
        rd(2'd0, d); chk("R4 readback staged", d, 8'h53);
        chk("R4 held during conv", {act_ref, act_chan}, {2'b11, 5'h07});
        repeat (3) tick();
        chk("R4 still held", {act_ref, act_chan}, {2'b11, 5'h07});
        finish_conv(10'h123);
        chk("R4 applied at done", {act_ref, act_chan}, {2'b01, 5'h13});
        chk("R10 busy after done", conv_busy, 0);

        // R5: write on the same cycle as done
        begin_conv();
        wr(2'd0, 8'h11);
        reg_wr_en = 1'b1; reg_addr = 2'd0; reg_wdata = 8'hE4;
        conv_done = 1'b1; conv_result = 10'h029;
        tick();
        reg_wr_en = 1'b0; conv_done = 1'b0;
        chk("R5 same-cycle write active", {act_ref, act_chan}, {2'b11, 5'h04});

        // R10: start and done together keep busy
        begin_conv();
        conv_start = 1'b1; conv_done = 1'b1; conv_result = 10'h029;
        tick();
        conv_start = 1'b0; conv_done = 1'b0;
        chk("R10 start+done busy", conv_busy, 1);

        // R6: alignment changes immediately even while busy
        wr(2'd0, 8'h20);
        rd(2'd2, hi); rd(2'd1, lo);
        chk("R6 left hi while busy", hi, 8'h0A);
        chk("R6 left lo while busy", lo, 8'h40);
        wr(2'd0, 8'h00);
        rd(2'd2, hi); rd(2'd1, lo);
        chk("R6 right hi while busy", hi, 8'h00);
        chk("R6 right lo while busy", lo, 8'h29);

        // R9: start and writes to result addresses ignored
        begin_conv();
        wr(2'd1, 8'hFF);
        wr(2'd2, 8'hFF);
        rd(2'd1, lo); rd(2'd2, hi);
        chk("R9 lo unchanged", lo, 8'h29);
        chk("R9 hi unchanged", hi, 8'h00);
        rd(2'd3, d); chk("R9 addr3 zero", d, 0);
        finish_conv(10'h000);

        // R7, R8: exhaustive sweep of results in both alignments
        for (int r = 0; r < 1024; r++) begin
            finish_conv(10'(r));
            wr(2'd0, 8'h00);
            rd(2'd1, lo); rd(2'd2, hi);
            chk("R7 right lo", lo, r & 8'hFF);
            chk("R7 right hi", hi, r >> 8);
            wr(2'd0, 8'h20);
            rd(2'd1, lo); rd(2'd2, hi);
            chk("R8 left lo", lo, (r & 3) << 6);
            chk("R8 left hi", hi, r >> 2);
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule